// File: doc/BRIEF.md
# NOR Flash Erase Command Sequence Decoder

This block sits on the write side of a parallel NOR memory bus and recognises the keyed six-write sequence that requests a sector erase. Each bus write presents a word address and a data byte. The block steps through the sequence while every write matches what the current step expects. A write that matches no expectation sends the block back to the start. When the sixth write names a target sector, the block checks that sector against a per-sector lock vector. It then either raises an erase request and holds a busy status for a fixed time, or reports a failure status without erasing.

The status byte follows the usual toggle-free convention: 0x80 means ready, 0x00 means an erase is in progress, and 0xA2 means the erase was refused because the sector is locked. The array itself is not part of this block. The erase request pulse and the sector number drive the array controller.

Top module: `nor_erase_seq_decoder`

## Requirements
- R1: After reset the status is 0x80, busy is 0 and erase_req is 0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address produce exactly one erase_req pulse. The pulse is high during the second clock cycle after the edge that samples the sixth write. erase_sector equals address bits [ADDR_W-1:ADDR_W-SECT_W] of that sixth write.
- R3: For the first five writes only the low KEY_W (11) address bits are compared. Higher address bits do not affect matching.
- R4: A write whose address or data differs from what the current step expects returns the decoder to step 0. The sequence must then restart from its first write.
- R5: A sixth write whose data is not 0x30 issues no erase and returns the decoder to step 0.
- R6: If the lock bit of the target sector is 1, no erase_req is issued. Instead the status becomes 0xA2 with busy 0, in the same cycle in which erase_req would have risen.
- R7: The 0xA2 status holds until the next bus write. The clock after that write shows 0x80, and the write itself is decoded as normal.
- R8: After an accepted erase, busy is 1 and the status is 0x00 for exactly ERASE_CYC clock cycles, starting in the erase_req cycle. The status then returns to 0x80.
- R9: Writes made while busy is 1 are ignored. A complete sequence written during busy issues no erase.
- R10: Clock cycles with wr_en low between the writes of a sequence do not disturb its progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| sector_lock | input | 2**SECT_W | Lock bit per sector, 1 = protected |
| busy | output | 1 | Erase in progress |
| status | output | 8 | 0x80 ready, 0x00 busy, 0xA2 lock failure |
| erase_req | output | 1 | One-cycle erase request to the array |
| erase_sector | output | SECT_W | Sector index for erase_req |

## Verification
The bench builds the block with ADDR_W=16, SECT_W=4 and ERASE_CYC=12. With a busy window this short, the bench can write a full sequence inside the busy window and can also measure the window's exact end, all within a short run. Sixteen sectors with two of them locked let both the refused and the accepted erase paths, and the sector decode, be driven through the same sequences. Upper address bits set on the unlock writes show that only the low eleven bits are compared.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_BUSY, ENG_FAIL} eng_state_t;

  localparam logic [7:0] STAT_READY = 8'h80;
  localparam logic [7:0] STAT_BUSY  = 8'h00;
  localparam logic [7:0] STAT_FAIL  = 8'hA2;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_SETUP  = 8'h80;
  localparam logic [7:0] KEY_ERASE  = 8'h30;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

  localparam int LAST_STEP = 5;
endpackage

// File: rtl/nor_seq_tracker.sv
module nor_seq_tracker
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4,
  parameter int KEY_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy_i,
  output logic              done_o,
  output logic [SECT_W-1:0] sect_o
);
  localparam logic [KEY_W-1:0] ADR_A = KEY_ADDR_A[KEY_W-1:0];
  localparam logic [KEY_W-1:0] ADR_B = KEY_ADDR_B[KEY_W-1:0];

  logic [2:0]       step_q;
  logic [KEY_W-1:0] exp_addr;
  logic [7:0]       exp_data;
  logic             addr_care;
  logic             hit;
  logic             accept;

  always_comb begin
    addr_care = 1'b1;
    exp_addr  = ADR_A;
    exp_data  = KEY_FIRST;
    unique case (step_q)
      3'd0: begin exp_addr = ADR_A; exp_data = KEY_FIRST;  end
      3'd1: begin exp_addr = ADR_B; exp_data = KEY_SECOND; end
      3'd2: begin exp_addr = ADR_A; exp_data = KEY_SETUP;  end
      3'd3: begin exp_addr = ADR_A; exp_data = KEY_FIRST;  end
      3'd4: begin exp_addr = ADR_B; exp_data = KEY_SECOND; end
      default: begin addr_care = 1'b0; exp_data = KEY_ERASE; end
    endcase
  end

  assign accept = wr_en && !busy_i;
  assign hit    = (!addr_care || (wr_addr[KEY_W-1:0] == exp_addr)) && (wr_data == exp_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 3'd0;
      done_o <= 1'b0;
      sect_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        if (!hit) begin
          step_q <= 3'd0;
        end else if (step_q == 3'(LAST_STEP)) begin
          step_q <= 3'd0;
          done_o <= 1'b1;
          sect_o <= wr_addr[ADDR_W-1 -: SECT_W];
        end else begin
          step_q <= step_q + 3'd1;
        end
      end
    end
  end

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (rst) step_q <= 3'(LAST_STEP));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) busy_i |=> $stable(step_q) && !done_o);
  // R5
  done_from_last_chk: assert property (@(posedge clk) disable iff (rst) $rose(done_o) |-> step_q == 3'd0);
endmodule

// File: rtl/nor_lock_lookup.sv
module nor_lock_lookup #(
  parameter int SECT_W = 4,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic [NUM_SECT-1:0] lock_vec,
  input  logic [SECT_W-1:0]   sect_i,
  output logic                locked_o
);
  logic [NUM_SECT-1:0] sel;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sel
    assign sel[i] = lock_vec[i] && (sect_i == SECT_W'(i));
  end

  assign locked_o = |sel;

  always_comb begin
    // R6
    one_sel_chk: assert ($onehot0(sel));
  end
endmodule

// File: rtl/nor_erase_engine.sv
module nor_erase_engine
  import nor_seq_pkg::*;
#(
  parameter int SECT_W    = 4,
  parameter int ERASE_CYC = 64,
  localparam int CNT_W    = $clog2(ERASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              done_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic              locked_i,
  output logic              busy,
  output logic [7:0]        status,
  output logic              erase_req,
  output logic [SECT_W-1:0] erase_sector
);
  eng_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ENG_IDLE;
      cnt_q        <= '0;
      busy         <= 1'b0;
      status       <= STAT_READY;
      erase_req    <= 1'b0;
      erase_sector <= '0;
    end else begin
      erase_req <= 1'b0;
      if (done_i && state_q != ENG_BUSY) begin
        if (locked_i) begin
          state_q <= ENG_FAIL;
          busy    <= 1'b0;
          status  <= STAT_FAIL;
        end else begin
          state_q      <= ENG_BUSY;
          cnt_q        <= CNT_W'(ERASE_CYC - 1);
          busy         <= 1'b1;
          status       <= STAT_BUSY;
          erase_req    <= 1'b1;
          erase_sector <= sect_i;
        end
      end else begin
        unique case (state_q)
          ENG_BUSY: begin
            if (cnt_q == '0) begin
              state_q <= ENG_IDLE;
              busy    <= 1'b0;
              status  <= STAT_READY;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          ENG_FAIL: begin
            if (wr_en) begin
              state_q <= ENG_IDLE;
              status  <= STAT_READY;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [CNT_W:0] win_q;
  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (erase_req) win_q <= (CNT_W+1)'(1);
    else if (busy) win_q <= win_q + 1'b1;
    else win_q <= '0;
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) erase_req |=> !erase_req);
  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (rst) erase_req |-> busy && status == STAT_BUSY);
  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> status == STAT_READY && win_q == (CNT_W+1)'(ERASE_CYC));
  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (rst) busy |-> win_q <= (CNT_W+1)'(ERASE_CYC));
  // R6
  fail_idle_chk: assert property (@(posedge clk) disable iff (rst) status == STAT_FAIL |-> !busy && !erase_req);
endmodule

// File: rtl/nor_erase_seq_decoder.sv
module nor_erase_seq_decoder #(
  parameter int ADDR_W    = 16,
  parameter int SECT_W    = 4,
  parameter int KEY_W     = 11,
  parameter int ERASE_CYC = 64,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [NUM_SECT-1:0] sector_lock,
  output logic                busy,
  output logic [7:0]          status,
  output logic                erase_req,
  output logic [SECT_W-1:0]   erase_sector
);
  logic              seq_done;
  logic [SECT_W-1:0] seq_sect;
  logic              sect_locked;

  nor_seq_tracker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .KEY_W(KEY_W)) u_track (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_i(busy), .done_o(seq_done), .sect_o(seq_sect)
  );

  nor_lock_lookup #(.SECT_W(SECT_W)) u_lock (
    .lock_vec(sector_lock), .sect_i(seq_sect), .locked_o(sect_locked)
  );

  nor_erase_engine #(.SECT_W(SECT_W), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst(rst), .wr_en(wr_en), .done_i(seq_done), .sect_i(seq_sect),
    .locked_i(sect_locked), .busy(busy), .status(status),
    .erase_req(erase_req), .erase_sector(erase_sector)
  );

  // R2
  req_after_done_chk: assert property (@(posedge clk) disable iff (rst) $rose(erase_req) |-> $past(seq_done));
endmodule

// File: tb/tb_nor_erase_seq_decoder.sv
module tb_nor_erase_seq_decoder;
  localparam int AW = 16, SW = 4, EC = 12;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] sector_lock = 16'h0012;
  logic busy, erase_req;
  logic [7:0] status;
  logic [SW-1:0] erase_sector;

  nor_erase_seq_decoder #(.ADDR_W(AW), .SECT_W(SW), .KEY_W(11), .ERASE_CYC(EC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sector_lock(sector_lock), .busy(busy), .status(status),
    .erase_req(erase_req), .erase_sector(erase_sector)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, pulses = 0, cycles = 0;
  int m_step, m_pend, m_psect, m_state, m_cnt, m_req, m_sect;
  int key_a[5] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA};
  int key_d[5] = '{'hAA, 'h55, 'h80, 'hAA, 'h55};

  // reference model, updated on each rising edge
  always @(posedge clk) begin
    int n_pend, n_psect, n_step;
    if (rst) begin
      m_step = 0; m_pend = 0; m_psect = 0; m_state = 0; m_cnt = 0; m_req = 0; m_sect = 0;
    end else begin
      n_pend = 0; n_psect = m_psect; n_step = m_step;
      if (wr_en && m_state != 1) begin
        if (m_step == 5) begin
          n_step = 0;
          if (wr_data == 8'h30) begin n_pend = 1; n_psect = int'(wr_addr) / 4096; end
        end else if (int'(wr_addr) % 2048 == key_a[m_step] && int'(wr_data) == key_d[m_step])
          n_step = m_step + 1;
        else n_step = 0;
      end
      m_req = 0;
      if (m_pend && m_state != 1) begin
        if (sector_lock[m_psect]) m_state = 2;
        else begin m_state = 1; m_cnt = EC; m_req = 1; m_sect = m_psect; end
      end else if (m_state == 1) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_state = 0;
      end else if (m_state == 2 && wr_en) m_state = 0;
      m_step = n_step; m_pend = n_pend; m_psect = n_psect;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int es;
    if (!rst) begin
      es = (m_state == 0) ? 'h80 : (m_state == 1) ? 'h00 : 'hA2;
      n_chk++;
      if (int'(status) != es || busy != (m_state == 1) || erase_req != m_req[0] ||
          (m_req != 0 && int'(erase_sector) != m_sect)) begin
        n_bad++;
        $display("FAIL R8/R6/R2 cycle %0d: status=%h busy=%b req=%b sect=%0d expected status=%h busy=%0d req=%0d sect=%0d",
                 cycles, status, busy, erase_req, erase_sector, es, m_state == 1, m_req, m_sect);
      end
      if (erase_req) pulses++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input int gap = 0);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d[7:0];
    @(negedge clk); wr_en = 0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic full_seq(input int sect, input int hi = 0, input int last = 'h30, input int gap = 0);
    wr(hi | 'h555, 'hAA, gap); wr(hi | 'h2AA, 'h55, gap); wr(hi | 'h555, 'h80, gap);
    wr(hi | 'h555, 'hAA, gap); wr(hi | 'h2AA, 'h55, gap); wr(sect * 4096 + 'h123, last, gap);
  endtask

  task automatic settle(); for (int i = 0; i < EC + 4; i++) @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 status", int'(status), 'h80);
    chk("R1 busy", int'(busy), 0);
    chk("R1 erase_req", int'(erase_req), 0);

    // R2 basic erase of sector 3
    pulses = 0; full_seq(3); settle();
    chk("R2 pulses", pulses, 1);
    // R8 exact window
    pulses = 0; full_seq(7);
    @(negedge clk);
    chk("R2 req timing", int'(erase_req), 1);
    chk("R2 sector", int'(erase_sector), 7);
    for (int i = 1; i < EC; i++) @(negedge clk);
    chk("R8 still busy", int'(busy), 1);
    @(negedge clk);
    chk("R8 ready after window", int'(status), 'h80);
    settle();

    // R3 upper address bits on unlock writes
    pulses = 0; full_seq(9, 'hF800); settle();
    chk("R3 pulses", pulses, 1);

    // R4 wrong data in step 3, then wrong address in step 2
    pulses = 0;
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h81);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h1000, 'h30); settle();
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h1000, 'h30); settle();
    chk("R4 pulses", pulses, 0);
    // R4 restart after abort succeeds
    wr('h555, 'hAA); wr('h555, 'hAA); full_seq(2); settle();
    chk("R4 restart pulses", pulses, 1);

    // R5 wrong final command
    pulses = 0; full_seq(5, 0, 'h10); settle();
    chk("R5 pulses", pulses, 0);

    // R6 locked sector 4
    pulses = 0; full_seq(4);
    @(negedge clk);
    chk("R6 status", int'(status), 'hA2);
    chk("R6 busy", int'(busy), 0);
    repeat (5) @(negedge clk);
    // R7 fail held until a write
    chk("R7 held", int'(status), 'hA2);
    wr('h0, 'h00);
    chk("R7 cleared", int'(status), 'h80);
    chk("R6 no pulse", pulses, 0);
    // R7 clearing write decoded as cycle 1
    pulses = 0;
    full_seq(1); @(negedge clk);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h6000, 'h30); settle();
    chk("R7 decoded clearing write", pulses, 1);

    // R9 sequence during busy
    pulses = 0; full_seq(8);
    @(negedge clk);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
    wr('h555, 'hAA); wr('h2AA, 'h55); wr('hA000, 'h30);
    settle(); settle();
    chk("R9 pulses", pulses, 1);

    // R10 idle gaps between writes
    pulses = 0; full_seq(12, 0, 'h30, 3); settle();
    chk("R10 pulses", pulses, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule